// File: doc/BRIEF.md
# Bidirectional Sampling Strobe Shifter

This block produces the column sampling strobes for a display source driver with 80 column positions. Each position has three channels, A, B and C, so there are 240 strobes in all. A single token enters from one of two edge pins. It then walks across the strobes, driven by three interleaved phase inputs, with exactly one strobe high at a time. The scan can run in either direction. The pin that is not accepting the token drives a carry to the next device in a chain, so several devices can scan one after another.

After the last strobe of a scan, the block stops responding to its phase inputs until a new token arrives. A separate output-enable input flips which of two sample banks is written and which one drives the panel. Everything runs on one system clock. The phase inputs and the output-enable input are treated as level signals that are synchronous to that clock, and the block acts on their rising edges.

Top module: `strobe_shifter`

## Requirements
- R1: While `rst_n` is low, at the next clock edge all strobes go low, the write bank becomes 0, the drive bank becomes 1 and both pin outputs go low.
- R2: At no time is more than one strobe high.
- R3: Strobe index k maps to position k/3+1 and channel A, B or C for k mod 3 equal to 0, 1 or 2. When `scan_fwd_i` is high, the token visits indices 0, 1, 2, ... up to 239. Each step is taken on a rising edge of the phase input that follows the current one in the cycle 1, 2, 3, 1, and so on.
- R4: When `scan_fwd_i` is low, the token starts at index 239 and visits 239, 238, ... down to 0. It uses the same 1, 2, 3 phase cycle.
- R5: A token is accepted only on a rising edge of phase 1, only while no strobe is high, and only from the pin selected by the direction. That is the right pin when `scan_fwd_i` is high and the left pin when it is low. The first strobe goes high on the same clock edge that sees the phase-1 rise.
- R6: A rising edge on a phase input that is not the next one in the cycle leaves the strobes unchanged.
- R7: When `scan_fwd_i` is high, the left pin drives (`pin_left_en_o`=1) and the right pin does not. When it is low, these roles swap. A pin that is not driving outputs 0.
- R8: The carry on the driving pin changes only on phase-1 rises. It goes high at the phase-1 step that enters the first strobe of the last position in scan order (index 237 forward, index 2 reverse). It goes low at the next phase-1 rise.
- R9: The phase step that follows the last strobe (index 239 forward, index 0 reverse) drops all strobes. Further phase edges without a new token leave them low.
- R10: A token presented on the input pin while a scan is running is ignored. The running token keeps its order.
- R11: Each rising edge of `oe_i` swaps the write and drive banks. A level held high gives only one swap. The drive bank is always the complement of the write bank.
- R12: A running scan keeps the direction captured when its token arrived, even if `scan_fwd_i` changes mid-scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_fwd_i | input | 1 | Scan direction, 1 = ascending indices |
| phase1_i | input | 1 | Phase 1 level |
| phase2_i | input | 1 | Phase 2 level |
| phase3_i | input | 1 | Phase 3 level |
| oe_i | input | 1 | Bank swap request, acts on rising edge |
| pin_right_i | input | 1 | Right edge pin, input side |
| pin_right_o | output | 1 | Right edge pin, output value |
| pin_right_en_o | output | 1 | Right edge pin, drive enable |
| pin_left_i | input | 1 | Left edge pin, input side |
| pin_left_o | output | 1 | Left edge pin, output value |
| pin_left_en_o | output | 1 | Left edge pin, drive enable |
| strobe_o | output | 240 | One-hot sampling strobes, index 3*(position-1)+channel |
| write_bank_o | output | 1 | Bank currently being written |
| drive_bank_o | output | 1 | Bank currently driving |

## Verification
Strobes, the carry and the bank selects are all due on the first rising clock edge at which the matching input is seen high after being low. There is no added pipeline stage. Pin enables follow `scan_fwd_i` with no clock at all. The bench raises an input at a falling edge, lowers it at the next falling edge, and reads every output at that second falling edge. At that point exactly one rising edge has elapsed, so every result is due. Steps that are meant to have no effect, such as off-cycle phases, a token arriving mid-scan or phases after the scan ends, are checked at the same moment against the unchanged expected index.

// File: rtl/strobe_shifter_pkg.sv
// Package: shared types for the sampling strobe shifter.
// Assumes: the three phase inputs are used in the fixed cycle 1 -> 2 -> 3 -> 1.
package strobe_shifter_pkg;

    typedef enum logic [1:0] {
        PH_ONE   = 2'd0,
        PH_TWO   = 2'd1,
        PH_THREE = 2'd2
    } phase_e;

    // Next phase in the interleaved cycle; the order is the same for both scan directions.
    function automatic phase_e phase_after(input phase_e cur);
        case (cur)
            PH_ONE:   return PH_TWO;
            PH_TWO:   return PH_THREE;
            default:  return PH_ONE;
        endcase
    endfunction

endpackage

// File: rtl/edge_rise.sv
// Module: edge_rise
// Flags the rising edge of each of WIDTH level inputs against clk.
// Assumes: the inputs are synchronous to clk; a pulse lasts one clock.
module edge_rise #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o
);

    logic [WIDTH-1:0] prev_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        // Remember the previous level of this bit.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[b] <= 1'b0;
            else        prev_q[b] <= level_i[b];
        end
        // Rise = now high, previously low.
        assign rise_o[b] = level_i[b] & ~prev_q[b];
    end

endmodule

// File: rtl/token_chain.sv
// Module: token_chain
// Bidirectional one-hot shift register of CHANNELS stages.
// load_i seeds stage 0 (forward) or the top stage (reverse).
// step_i moves the token by one stage in the direction fwd_i.
// Also exports the next-state value of the two stages that start the last
// position in each scan order, for the carry logic.
// Assumes: load_i is only asserted while the chain is empty.
module token_chain #(
    parameter int CHANNELS = 240
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                step_i,
    input  logic                fwd_i,
    output logic [CHANNELS-1:0] token_o,
    output logic                tail_fwd_nxt_o,
    output logic                tail_rev_nxt_o
);

    localparam int TOP      = CHANNELS - 1;
    localparam int TAIL_FWD = CHANNELS - 3;
    localparam int TAIL_REV = 2;

    logic [CHANNELS-1:0] token_q;
    logic [CHANNELS-1:0] token_d;

    for (genvar i = 0; i < CHANNELS; i++) begin : g_stage
        logic from_lo;
        logic from_hi;
        logic seed;
        if (i == 0) begin : g_lo_edge
            assign from_lo = 1'b0;
        end else begin : g_lo_mid
            assign from_lo = token_q[i-1];
        end
        if (i == TOP) begin : g_hi_edge
            assign from_hi = 1'b0;
        end else begin : g_hi_mid
            assign from_hi = token_q[i+1];
        end
        if (i == 0 && i == TOP) begin : g_seed_both
            assign seed = 1'b1;
        end else if (i == 0) begin : g_seed_lo
            assign seed = fwd_i;
        end else if (i == TOP) begin : g_seed_hi
            assign seed = ~fwd_i;
        end else begin : g_seed_none
            assign seed = 1'b0;
        end

        // Next value of this stage: seed on load, neighbour on step, else hold.
        always_comb begin
            if (load_i)      token_d[i] = seed;
            else if (step_i) token_d[i] = fwd_i ? from_lo : from_hi;
            else             token_d[i] = token_q[i];
        end

        // Stage register.
        always_ff @(posedge clk) begin
            if (!rst_n) token_q[i] <= 1'b0;
            else        token_q[i] <= token_d[i];
        end
    end

    assign token_o        = token_q;
    assign tail_fwd_nxt_o = token_d[TAIL_FWD];
    assign tail_rev_nxt_o = token_d[TAIL_REV];

    AST_ONE_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(token_q)); // R2

    AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !load_i) |=> $stable(token_q)); // R6

    AST_LOAD_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (token_q == '0)); // R10

endmodule

// File: rtl/scan_ctrl.sv
// Module: scan_ctrl
// Decides when the token chain loads or steps. Tracks which phase is due
// next and latches the scan direction when a token arrives. Owns the edge
// pins: it picks the start input, drives the carry on the opposite pin and
// updates the carry only on phase-1 rises.
// Assumes: phase rises are one-clock pulses; busy_i is high while any strobe is.
module scan_ctrl
    import strobe_shifter_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dir_i,
    input  logic [2:0] ph_rise_i,
    input  logic       busy_i,
    input  logic       tail_fwd_nxt_i,
    input  logic       tail_rev_nxt_i,
    input  logic       right_i,
    input  logic       left_i,
    output logic       load_o,
    output logic       step_o,
    output logic       fwd_o,
    output logic       right_o,
    output logic       right_en_o,
    output logic       left_o,
    output logic       left_en_o
);

    phase_e due_q;
    logic   dir_q;
    logic   carry_q;
    logic   start_in;
    logic   due_rise;

    // Start input comes from the pin opposite the carry.
    assign start_in = dir_i ? right_i : left_i;

    // Rise of the phase that is due next.
    always_comb begin
        case (due_q)
            PH_ONE:   due_rise = ph_rise_i[0];
            PH_TWO:   due_rise = ph_rise_i[1];
            default:  due_rise = ph_rise_i[2];
        endcase
    end

    assign load_o = ~busy_i & ph_rise_i[0] & start_in;
    assign step_o = busy_i & due_rise;
    assign fwd_o  = load_o ? dir_i : dir_q;

    // Advance the due phase on every load or step.
    always_ff @(posedge clk) begin
        if (!rst_n)      due_q <= PH_TWO;
        else if (load_o) due_q <= PH_TWO;
        else if (step_o) due_q <= phase_after(due_q);
    end

    // Capture the direction together with the token.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= 1'b1;
        else if (load_o) dir_q <= dir_i;
    end

    // Carry follows the last position's first stage, sampled on phase-1 rises only.
    always_ff @(posedge clk) begin
        if (!rst_n)            carry_q <= 1'b0;
        else if (ph_rise_i[0]) carry_q <= fwd_o ? tail_fwd_nxt_i : tail_rev_nxt_i;
    end

    assign right_en_o = ~dir_i;
    assign left_en_o  = dir_i;
    assign right_o    = ~dir_i & carry_q;
    assign left_o     = dir_i & carry_q;

    AST_CARRY_ON_PHASE1: assert property (@(posedge clk) disable iff (!rst_n)
        !ph_rise_i[0] |=> $stable(carry_q)); // R8

    AST_DIR_HELD_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !load_o) |=> $stable(dir_q)); // R12

endmodule

// File: rtl/bank_sel.sv
// Module: bank_sel
// Ping-pong selection between two sample banks. Each enable rise swaps them.
// Assumes: swap_i is a one-clock rise pulse.
module bank_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic swap_i,
    output logic write_bank_o,
    output logic drive_bank_o
);

    logic wr_q;

    // Flip the write bank on each swap request.
    always_ff @(posedge clk) begin
        if (!rst_n)      wr_q <= 1'b0;
        else if (swap_i) wr_q <= ~wr_q;
    end

    assign write_bank_o = wr_q;
    assign drive_bank_o = ~wr_q;

    AST_BANK_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        swap_i |=> (wr_q != $past(wr_q))); // R11

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_i |=> $stable(wr_q)); // R11

endmodule

// File: rtl/strobe_shifter.sv
// Module: strobe_shifter (top)
// Sampling strobe generator for POSITIONS column triplets. Ties together the
// edge detector, the scan control, the token chain and the bank selector.
// Assumes: all level inputs are synchronous to clk.
module strobe_shifter #(
    parameter int POSITIONS = 80,
    localparam int CHANNELS = 3 * POSITIONS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scan_fwd_i,
    input  logic                phase1_i,
    input  logic                phase2_i,
    input  logic                phase3_i,
    input  logic                oe_i,
    input  logic                pin_right_i,
    output logic                pin_right_o,
    output logic                pin_right_en_o,
    input  logic                pin_left_i,
    output logic                pin_left_o,
    output logic                pin_left_en_o,
    output logic [CHANNELS-1:0] strobe_o,
    output logic                write_bank_o,
    output logic                drive_bank_o
);

    logic [3:0] rise;
    logic       load;
    logic       step;
    logic       fwd;
    logic       busy;
    logic       tail_fwd_nxt;
    logic       tail_rev_nxt;

    edge_rise #(.WIDTH(4)) u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i ({oe_i, phase3_i, phase2_i, phase1_i}),
        .rise_o  (rise)
    );

    scan_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .dir_i          (scan_fwd_i),
        .ph_rise_i      (rise[2:0]),
        .busy_i         (busy),
        .tail_fwd_nxt_i (tail_fwd_nxt),
        .tail_rev_nxt_i (tail_rev_nxt),
        .right_i        (pin_right_i),
        .left_i         (pin_left_i),
        .load_o         (load),
        .step_o         (step),
        .fwd_o          (fwd),
        .right_o        (pin_right_o),
        .right_en_o     (pin_right_en_o),
        .left_o         (pin_left_o),
        .left_en_o      (pin_left_en_o)
    );

    token_chain #(.CHANNELS(CHANNELS)) u_chain (
        .clk            (clk),
        .rst_n          (rst_n),
        .load_i         (load),
        .step_i         (step),
        .fwd_i          (fwd),
        .token_o        (strobe_o),
        .tail_fwd_nxt_o (tail_fwd_nxt),
        .tail_rev_nxt_o (tail_rev_nxt)
    );

    // Scan is running while any strobe is high.
    assign busy = |strobe_o;

    bank_sel u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .swap_i       (rise[3]),
        .write_bank_o (write_bank_o),
        .drive_bank_o (drive_bank_o)
    );

    AST_IDLE_STAYS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(phase1_i && (scan_fwd_i ? pin_right_i : pin_left_i))) |=> (strobe_o == '0)); // R9

endmodule

// File: tb/strobe_shifter_test.sv
module strobe_shifter_test;

    localparam int POS  = 80;
    localparam int NCH  = 3 * POS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_fwd = 1'b1;
    logic ph1 = 1'b0, ph2 = 1'b0, ph3 = 1'b0, oe = 1'b0;
    logic pr_i = 1'b0, pl_i = 1'b0;
    logic pr_o, pr_en, pl_o, pl_en;
    logic [NCH-1:0] strobe;
    logic wr_bank, dr_bank;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    strobe_shifter #(.POSITIONS(POS)) uut (
        .clk(clk), .rst_n(rst_n), .scan_fwd_i(scan_fwd),
        .phase1_i(ph1), .phase2_i(ph2), .phase3_i(ph3), .oe_i(oe),
        .pin_right_i(pr_i), .pin_right_o(pr_o), .pin_right_en_o(pr_en),
        .pin_left_i(pl_i), .pin_left_o(pl_o), .pin_left_en_o(pl_en),
        .strobe_o(strobe), .write_bank_o(wr_bank), .drive_bank_o(dr_bank)
    );

    // Index of the single high strobe: -1 none, -2 more than one.
    function automatic int strobe_index();
        int found = -1;
        for (int i = 0; i < NCH; i++) begin
            if (strobe[i]) found = (found == -1) ? i : -2;
        end
        return found;
    endfunction

    task automatic check_int(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // Raise one input for a clock and return at the falling edge after the acting edge.
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            1: ph1 = 1'b1;
            2: ph2 = 1'b1;
            3: ph3 = 1'b1;
            default: oe = 1'b1;
        endcase
        @(negedge clk);
        ph1 = 1'b0; ph2 = 1'b0; ph3 = 1'b0; oe = 1'b0;
    endtask

    task automatic check_pins(input string req, input int carry);
        if (scan_fwd) begin
            check_int({req, " left en"}, int'(pl_en), 1);
            check_int({req, " right en"}, int'(pr_en), 0);
            check_int({req, " right out"}, int'(pr_o), 0);
            check_int({req, " carry"}, int'(pl_o), carry);
        end else begin
            check_int({req, " right en"}, int'(pr_en), 1);
            check_int({req, " left en"}, int'(pl_en), 0);
            check_int({req, " left out"}, int'(pl_o), 0);
            check_int({req, " carry"}, int'(pr_o), carry);
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_int("R1 strobes", strobe_index(), -1);
        check_int("R1 write bank", int'(wr_bank), 0);
        check_int("R1 drive bank", int'(dr_bank), 1);
        check_int("R1 pin out", int'(pr_o | pl_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_int("R1 after release", strobe_index(), -1);
    endtask

    task automatic test_start_rules();
        scan_fwd = 1'b1;
        pl_i = 1'b1;               // wrong side for forward scan
        pulse(1);
        check_int("R5 wrong pin", strobe_index(), -1);
        pl_i = 1'b0; pr_i = 1'b1;  // right side, but not phase 1
        pulse(2);
        check_int("R5 not phase1", strobe_index(), -1);
        pulse(3);
        check_int("R5 not phase1 p3", strobe_index(), -1);
        pr_i = 1'b0;
        check_pins("R7 idle fwd", 0);
    endtask

    task automatic test_forward();
        scan_fwd = 1'b1;
        pr_i = 1'b1;
        pulse(1);
        pr_i = 1'b0;
        check_int("R5 R3 first strobe", strobe_index(), 0);
        for (int k = 1; k < NCH; k++) begin
            int ph = k % 3 + 1;
            if (k == 100) begin
                pulse(ph % 3 + 1);
                check_int("R6 off-cycle phase", strobe_index(), k - 1);
            end
            if (k == 150) pr_i = 1'b1;
            pulse(ph);
            pr_i = 1'b0;
            check_int(k == 150 ? "R10 start mid-scan" : "R3 forward order", strobe_index(), k);
            check_int("R2 single strobe", $countones(strobe) <= 1 ? 1 : 0, 1);
            if (ph == 1) check_pins("R8 R7 fwd", (k == NCH - 3) ? 1 : 0);
        end
        pulse(1);
        check_int("R9 end of forward scan", strobe_index(), -1);
        check_pins("R8 carry drop fwd", 0);
        pulse(2); pulse(3); pulse(1);
        check_int("R9 suspended", strobe_index(), -1);
    endtask

    task automatic test_reverse();
        scan_fwd = 1'b0;
        pl_i = 1'b1;
        pulse(1);
        pl_i = 1'b0;
        check_int("R4 R5 first strobe", strobe_index(), NCH - 1);
        check_pins("R7 rev", 0);
        for (int k = 1; k < NCH; k++) begin
            int ph = k % 3 + 1;
            if (k == 60) scan_fwd = 1'b1;
            pulse(ph);
            if (k == 60) begin
                check_int("R12 direction held", strobe_index(), NCH - 1 - k);
                scan_fwd = 1'b0;
            end else begin
                check_int("R4 reverse order", strobe_index(), NCH - 1 - k);
            end
            if (ph == 1 && k != 60) check_pins("R8 R7 rev", (NCH - 1 - k == 2) ? 1 : 0);
        end
        pulse(1);
        check_int("R9 end of reverse scan", strobe_index(), -1);
        check_pins("R8 carry drop rev", 0);
        pulse(2); pulse(3);
        check_int("R9 suspended rev", strobe_index(), -1);
    endtask

    task automatic test_banks();
        pulse(4);
        check_int("R11 write bank swap", int'(wr_bank), 1);
        check_int("R11 drive bank swap", int'(dr_bank), 0);
        @(negedge clk); oe = 1'b1;
        repeat (5) @(negedge clk);
        oe = 1'b0;
        @(negedge clk);
        check_int("R11 held level swaps once", int'(wr_bank), 0);
        check_int("R11 complement", int'(dr_bank), 1);
    endtask

    initial begin
        test_reset();
        test_start_rules();
        test_forward();
        test_reverse();
        test_banks();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule